// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two 32-bit descriptors from memory and decodes them. A request is accepted only while the walker is idle. At that moment the walker latches the virtual address, the translation table base and the tiny-page enable. It then fetches the first-level descriptor.

The first-level descriptor either ends the walk or points to a second-level table. A fault or a section ends the walk. A coarse or fine table pointer leads to a second read. The leaf descriptor then yields the physical address, the page kind, the domain, the cacheable/bufferable pair and the access-permission field. Each leaf kind splits the address differently between descriptor base and virtual-address offset.

Reads leave on a valid/ready request channel. The walker holds `mem_req_valid` and the address steady until `mem_req_ready` is seen high on a clock edge, so the memory side may stall for any number of cycles. Read data comes back on a one-cycle `mem_rsp_valid` strobe. The memory must not raise this strobe unless a read is outstanding, and the walker accepts it in any cycle. At the end of each walk `done` pulses for one cycle. All result outputs change only in that cycle and hold until the next walk completes.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The first read goes to `{tbase[31:14], req_vaddr[31:20], 2'b00}`.
- R2: A first-level descriptor with bits [1:0] = 00 ends the walk after one read, as a fault.
- R3: A first-level descriptor with bits [1:0] = 11 is a fault when the `tiny_en` value latched with the request is 0. With `tiny_en` = 1 it selects a fine second-level table.
- R4: For every result that is not a fault, `domain` equals first-level descriptor bits [8:5].
- R5: First-level type 10 (section) ends the walk after one read. The results are `page_kind` = 0, `cb` = bits [3:2], `ap` = {6'b0, bits [11:10]} and `phys_addr` = {desc[31:20], va[19:0]}.
- R6: First-level type 01 (coarse) reads the second level at `{desc[31:10], va[19:12], 2'b00}`.
- R7: First-level type 11 with tiny pages enabled (fine) reads the second level at `{desc[31:12], va[19:10], 2'b00}`.
- R8: A second-level descriptor with bits [1:0] = 00 is a fault. For any other second-level type, `cb` equals its bits [3:2].
- R9: Second-level type 01 (large) gives `page_kind` = 1, `ap` = bits [11:4] and `phys_addr` = {desc[31:16], va[15:0]}.
- R10: Second-level type 10 (small) gives `page_kind` = 2, `ap` = bits [11:4] and `phys_addr` = {desc[31:12], va[11:0]}.
- R11: Second-level type 11 (tiny) gives `page_kind` = 3, `ap` = {6'b0, bits [5:4]} and `phys_addr` = {desc[31:10], va[9:0]}.
- R12: `done` is a one-cycle pulse per walk, and the result outputs change only in that cycle. A fault gives `fault` = 1, `page_kind` = 7 and zero for `phys_addr`, `domain`, `cb` and `ap`. After reset the outputs are zero, except `page_kind`, which is 7.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address hold. Changes to `tbase` or `tiny_en` during a walk have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| tbase | input | 32 | Translation table base, bits [31:14] used |
| tiny_en | input | 1 | Enables fine tables and tiny pages |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the descriptor to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle end-of-walk pulse |
| phys_addr | output | 32 | Translated address |
| page_kind | output | 3 | 0 section, 1 large, 2 small, 3 tiny, 7 fault |
| domain | output | 4 | Domain number |
| cb | output | 2 | Cacheable/bufferable bits |
| ap | output | 8 | Access-permission field, zero-extended |
| fault | output | 1 | Translation fault |

## Verification
A corrupted walk state shows up at the ports within one cycle. A wrong state can raise `mem_req_valid` when no read is due, send a read to an address other than the one predicted for that stage, drop `req_ready` while idle, or pulse `done` at the wrong time or with a wrong page kind. A wrong latched descriptor or wrong latched base is seen at the next handshake, as a wrong read address, or at the next `done`, as a wrong result field. The bench predicts every read address and every result from its own model. It also checks on every clock that the result outputs hold between pulses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WORD_W = 32;
  localparam int DOM_W  = 4;
  localparam int CB_W   = 2;
  localparam int AP_W   = 8;
  localparam int OFS_W  = 20;

  typedef enum logic [2:0] {
    KIND_SECTION = 3'd0,
    KIND_LARGE   = 3'd1,
    KIND_SMALL   = 3'd2,
    KIND_TINY    = 3'd3,
    KIND_BAD     = 3'd7
  } page_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] pa;
    page_kind_e        kind;
    logic [DOM_W-1:0]  dom;
    logic [CB_W-1:0]   cb;
    logic [AP_W-1:0]   ap;
    logic              fault;
  } xlat_res_t;

  function automatic xlat_res_t fault_res();
    xlat_res_t r;
    r       = '0;
    r.kind  = KIND_BAD;
    r.fault = 1'b1;
    return r;
  endfunction

  function automatic xlat_res_t idle_res();
    xlat_res_t r;
    r      = '0;
    r.kind = KIND_BAD;
    return r;
  endfunction
endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
  import xlat_pkg::*;
(
  input  logic [WORD_W-1:0] desc,
  input  logic [OFS_W-1:0]  va_lo,
  input  logic              tiny_en,
  output logic              is_fault,
  output logic              is_leaf,
  output logic [WORD_W-1:0] next_addr,
  output logic [DOM_W-1:0]  dom,
  output xlat_res_t         leaf_res
);
  logic unused_bits;
  assign unused_bits = ^{desc[9], desc[4]};

  assign dom = desc[8:5];

  always_comb begin
    is_fault  = 1'b0;
    is_leaf   = 1'b0;
    next_addr = '0;
    unique case (desc[1:0])
      2'b00: is_fault = 1'b1;
      2'b10: is_leaf  = 1'b1;
      2'b01: next_addr = {desc[31:10], va_lo[19:12], 2'b00};
      2'b11: begin
        is_fault  = !tiny_en;
        next_addr = {desc[31:12], va_lo[19:10], 2'b00};
      end
    endcase
  end

  always_comb begin
    leaf_res       = '0;
    leaf_res.pa    = {desc[31:20], va_lo};
    leaf_res.kind  = KIND_SECTION;
    leaf_res.dom   = desc[8:5];
    leaf_res.cb    = desc[3:2];
    leaf_res.ap    = {{(AP_W-2){1'b0}}, desc[11:10]};
    leaf_res.fault = 1'b0;
  end
endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
  import xlat_pkg::*;
(
  input  logic [WORD_W-1:0] desc,
  input  logic [OFS_W-1:0]  va_lo,
  input  logic [DOM_W-1:0]  dom,
  output xlat_res_t         res
);
  always_comb begin
    res       = '0;
    res.dom   = dom;
    res.cb    = desc[3:2];
    res.fault = 1'b0;
    unique case (desc[1:0])
      2'b00: res = fault_res();
      2'b01: begin
        res.kind = KIND_LARGE;
        res.ap   = desc[11:4];
        res.pa   = {desc[31:16], va_lo[15:0]};
      end
      2'b10: begin
        res.kind = KIND_SMALL;
        res.ap   = desc[11:4];
        res.pa   = {desc[31:12], va_lo[11:0]};
      end
      2'b11: begin
        res.kind = KIND_TINY;
        res.ap   = {{(AP_W-2){1'b0}}, desc[5:4]};
        res.pa   = {desc[31:10], va_lo[9:0]};
      end
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_vaddr,
  input  logic [WORD_W-1:0] tbase,
  input  logic              tiny_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [WORD_W-1:0] phys_addr,
  output logic [2:0]        page_kind,
  output logic [DOM_W-1:0]  domain,
  output logic [CB_W-1:0]   cb,
  output logic [AP_W-1:0]   ap,
  output logic              fault
);
  localparam int TB_LO = 14;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT
  } walk_st_e;

  walk_st_e                state_q;
  logic [WORD_W-1:0]       va_q;
  logic [WORD_W-1:TB_LO]   tb_q;
  logic                    tiny_q;
  logic [WORD_W-1:0]       l1_q;
  xlat_res_t               res_q;
  logic                    done_q;

  logic [WORD_W-1:0]       l1_desc;
  logic                    l1_fault, l1_leaf;
  logic [WORD_W-1:0]       l2_addr;
  logic [DOM_W-1:0]        l1_dom;
  xlat_res_t               sec_res, l2_res;

  assign l1_desc = (state_q == S_L1_WAIT) ? mem_rsp_data : l1_q;

  xlat_l1_dec u_l1 (
    .desc(l1_desc), .va_lo(va_q[OFS_W-1:0]), .tiny_en(tiny_q),
    .is_fault(l1_fault), .is_leaf(l1_leaf), .next_addr(l2_addr),
    .dom(l1_dom), .leaf_res(sec_res)
  );

  xlat_l2_dec u_l2 (
    .desc(mem_rsp_data), .va_lo(va_q[OFS_W-1:0]), .dom(l1_dom), .res(l2_res)
  );

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign mem_req_addr  = (state_q == S_L2_REQ) ? l2_addr
                                               : {tb_q, va_q[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      tb_q    <= '0;
      tiny_q  <= 1'b0;
      l1_q    <= '0;
      res_q   <= idle_res();
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          tb_q    <= tbase[WORD_W-1:TB_LO];
          tiny_q  <= tiny_en;
          state_q <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          l1_q <= mem_rsp_data;
          if (l1_fault) begin
            res_q   <= fault_res();
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (l1_leaf) begin
            res_q   <= sec_res;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_L2_REQ;
          end
        end
        S_L2_REQ: if (mem_req_ready) state_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          res_q   <= l2_res;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign phys_addr = res_q.pa;
  assign page_kind = res_q.kind;
  assign domain    = res_q.dom;
  assign cb        = res_q.cb;
  assign ap        = res_q.ap;
  assign fault     = res_q.fault;

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(phys_addr) && $stable(page_kind) && $stable(ap)
               && $stable(cb) && $stable(domain) && $stable(fault)));

  a_r12_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault == (page_kind == 3'd7)));

  a_r11_tiny_ap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_kind == 3'd3) |-> (ap[7:2] == 6'd0));

  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  import xlat_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0, tbase = '0;
  logic tiny_en = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done, fault;
  logic [31:0] phys_addr;
  logic [2:0] page_kind;
  logic [3:0] domain;
  logic [1:0] cb;
  logic [7:0] ap;

  always #10 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .tbase, .tiny_en,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid,
    .mem_rsp_data, .done, .phys_addr, .page_kind, .domain, .cb, .ap, .fault
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [logic [31:0]];
  xlat_res_t exp_q [$];
  string     exp_tag [$];
  logic [31:0] addr_q [$];
  string     addr_tag [$];
  xlat_res_t last_res;
  bit busy = 0, hs_prev = 0, cnt_on = 0, running = 0;
  int cnt = 0, lat_cfg = 0, stall_mode = 0, cyc = 0;
  logic [31:0] hs_addr = '0, rd_addr = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic xlat_res_t bad();
    xlat_res_t r; r = '0; r.kind = KIND_BAD; r.fault = 1; return r;
  endfunction

  // Behavioural model: builds expected reads and result for one walk.
  task automatic walk(input string tag, input logic [31:0] va, input logic [31:0] tb,
                      input bit tiny, input logic [31:0] d1, input logic [31:0] d2,
                      input bit disturb);
    xlat_res_t r;
    logic [31:0] a1, a2;
    int t1, t2;
    r = '0;
    a1 = (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
    mem[a1] = d1;
    addr_q.push_back(a1); addr_tag.push_back("R1");
    t1 = d1 % 4;
    if (t1 == 0 || (t1 == 3 && !tiny)) r = bad();
    else if (t1 == 2) begin
      r.pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      r.kind = KIND_SECTION; r.dom = (d1 >> 5) % 16;
      r.cb = (d1 >> 2) % 4; r.ap = (d1 >> 10) % 4;
    end else begin
      if (t1 == 1) begin
        a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) % 256) * 4);
        addr_tag.push_back("R6");
      end else begin
        a2 = (d1 & 32'hFFFF_F000) | (((va >> 10) % 1024) * 4);
        addr_tag.push_back("R7");
      end
      mem[a2] = d2;
      addr_q.push_back(a2);
      t2 = d2 % 4;
      r.dom = (d1 >> 5) % 16;
      r.cb  = (d2 >> 2) % 4;
      case (t2)
        0: r = bad();
        1: begin r.kind = KIND_LARGE; r.ap = (d2 >> 4) % 256;
                 r.pa = (d2 & 32'hFFFF_0000) | (va % 32'h1_0000); end
        2: begin r.kind = KIND_SMALL; r.ap = (d2 >> 4) % 256;
                 r.pa = (d2 & 32'hFFFF_F000) | (va % 32'h1000); end
        default: begin r.kind = KIND_TINY; r.ap = (d2 >> 4) % 4;
                 r.pa = (d2 & 32'hFFFF_FC00) | (va % 32'h400); end
      endcase
    end
    exp_q.push_back(r); exp_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; tbase = tb; tiny_en = tiny;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_vaddr = ~va;
    if (disturb) begin tbase = ~tb; tiny_en = ~tiny; end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor and memory model, stepping 5 ns before each rising edge.
  initial begin
    forever begin
      @(negedge clk); #5;
      if (running) begin
        cyc++;
        if (cyc > 20000) begin
          check(0, "WD", "watchdog", cyc, 0);
          summary();
        end
        if (done) begin
          if (exp_q.size() == 0) check(0, "R12", "unexpected done", 1, 0);
          else begin
            xlat_res_t e; string t;
            e = exp_q.pop_front(); t = exp_tag.pop_front();
            check(phys_addr == e.pa, t, "phys_addr", phys_addr, e.pa);
            check(page_kind == e.kind && fault == e.fault, t, "kind/fault",
                  {page_kind, fault}, {e.kind, e.fault});
            check(domain == e.dom && cb == e.cb && ap == e.ap, t, "dom/cb/ap",
                  {domain, cb, ap}, {e.dom, e.cb, e.ap});
          end
          busy = 0;
          last_res = '{pa:phys_addr, kind:page_kind_e'(page_kind), dom:domain,
                       cb:cb, ap:ap, fault:fault};
        end else begin
          check(phys_addr == last_res.pa && page_kind == last_res.kind &&
                domain == last_res.dom && cb == last_res.cb &&
                ap == last_res.ap && fault == last_res.fault,
                "R12", "outputs held", {phys_addr, page_kind}, {last_res.pa, last_res.kind});
        end
        check(req_ready == !busy, "R1", "req_ready", req_ready, !busy);
        if (mem_rsp_valid) mem_rsp_valid = 0;
        if (hs_prev) begin cnt_on = 1; cnt = lat_cfg; rd_addr = hs_addr; end
        if (cnt_on) begin
          if (cnt == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data = mem.exists(rd_addr) ? mem[rd_addr] : 32'hDEAD_0000;
            cnt_on = 0;
          end else cnt--;
        end
        mem_req_ready = (stall_mode != 0) ? (cyc % 3 == 2) : 1'b1;
        hs_prev = mem_req_valid && mem_req_ready;
        if (hs_prev) begin
          hs_addr = mem_req_addr;
          if (addr_q.size() == 0) check(0, "R1", "unexpected read", mem_req_addr, 0);
          else begin
            logic [31:0] ea; string at;
            ea = addr_q.pop_front(); at = addr_tag.pop_front();
            check(mem_req_addr == ea, at, "read address", mem_req_addr, ea);
          end
        end
        if (req_valid && req_ready) busy = 1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1 && done == 0 && fault == 0 && page_kind == 3'd7 &&
          phys_addr == 0 && ap == 0 && cb == 0 && domain == 0 && !mem_req_valid,
          "R12", "reset state", {page_kind, phys_addr}, {3'd7, 32'd0});
    rst_n = 1;
    last_res = '0; last_res.kind = KIND_BAD;
    running = 1;
    @(negedge clk);
    walk("R5/R4", 32'h1234_5678, 32'h0008_4000, 0, 32'hABC0_0DEE, 0, 0);
    walk("R2", 32'h0030_0000, 32'h0008_4000, 0, 32'h5555_5554, 0, 0);
    walk("R3", 32'h0040_1000, 32'h0008_4000, 0, 32'h0020_01E3, 0, 0);
    lat_cfg = 1;
    walk("R9/R8", 32'h0051_2345, 32'h0010_0000, 0, 32'h0020_0021, 32'hCAFE_5A5D, 0);
    walk("R10/R8", 32'h0062_3ABC, 32'h0010_0000, 1, 32'h0020_4141, 32'h7654_3F3A, 0);
    walk("R8", 32'h0073_3000, 32'h0010_0000, 0, 32'h0020_8001, 32'hFFFF_FFFC, 0);
    lat_cfg = 2;
    walk("R11/R7", 32'h0084_56F1, 32'h0010_0000, 1, 32'h0030_01C3, 32'h1357_9BFF, 0);
    walk("R10/R7", 32'h0095_7777, 32'h0010_0000, 1, 32'h0031_0003, 32'hABCD_E00E, 0);
    walk("R11/R6", 32'h00A6_8BCD, 32'h0010_0000, 0, 32'h0032_0061, 32'h2468_AC37, 0);
    stall_mode = 1;
    walk("R13/R5", 32'hFEDC_BA98, 32'h0020_0000, 0, 32'h8760_0C0A, 0, 1);
    walk("R13/R7", 32'h00B7_9C01, 32'h0020_0000, 1, 32'h0033_0123, 32'h0F0F_0F33, 1);
    walk("R13/R3", 32'h00C8_0000, 32'h0020_0000, 0, 32'h0034_0003, 0, 1);
    stall_mode = 0; lat_cfg = 0;
    walk("R4/R9", 32'h00D9_0001, 32'h0030_0000, 0, 32'h0035_01E1, 32'h4000_0FF5, 0);
    check(exp_q.size() == 0 && addr_q.size() == 0, "R12", "all walks done",
          exp_q.size(), 0);
    summary();
  end
endmodule